// File: doc/BRIEF.md
# Video DRAM Write Masking Data Path

This block forms the write request for one row access of a video DRAM array. A decoder upstream tells it which kind of cycle began at the row strobe fall. The block also receives single-cycle pulses for the write-enable fall and for the first fall of a column strobe. The block holds a 16-bit color register and a 16-bit write-mask register. From these, the data pins and the column address it produces a one-cycle write request. The request is a per-column enable vector, a per-bit enable vector and the 16-bit write data, which drive a simple array model.

A plain write sends the data-pin value to one column. A block write copies the color register into an aligned group of BLOCK adjacent columns. In that case the data pins act as the column mask. In both cases an I/O bit mask gates which data bits land. That mask comes from the data pins at the row strobe fall (per-cycle), from the stored write-mask register (persistent mode), or is all ones (nonmasked cycles). Two byte-lane column strobe enables further gate the low and high byte.

Top module: `vwr_mask_path`

## Requirements
- R1: After reset the color register and write-mask register are zero, persistent mode is off and all outputs (wrValid, colWe, bitEn, wrData) are zero.
- R2: Data pins are latched at whichever comes later: the weFall pulse or the first casFall pulse of the access. Both may arrive in the same cycle. The write request appears in the cycle after that latch and lasts exactly one cycle. Strobes are ignored in the rasFall cycle and while no access is open. cycleKind codes are: 0 idle, 1 write, 2 masked write, 3 block write, 4 masked block write, 5 load write-mask, 6 load color, 7 mode reset.
- R3: A load-color access (code 6) stores the latched data pins into the color register and raises no write request.
- R4: A load-write-mask access (code 5) stores the latched data pins into the write-mask register, turns persistent mode on and raises no write request.
- R5: A plain write (code 1) sets only colWe bit equal to the column address latched at the first casFall. It drives wrData with the latched data pins, and all 16 I/O bits are enabled before lane gating.
- R6: A masked write or masked block write outside persistent mode uses the data-pin value sampled at rasFall as the I/O mask. A bit set to 1 enables that I/O bit.
- R7: In persistent mode, masked cycles use the stored write-mask register instead of the rasFall data pins.
- R8: A block write (codes 3, 4) with BLOCK=4 uses the column address with its low two bits cleared as the base. It sets colWe[base+k] when latched data bit k is 1, for k in 0..3, and drives wrData with the color register. Nonmasked block writes enable all I/O bits.
- R9: casLowEn and casHighEn, sampled at the first casFall, gate bitEn bits 7:0 and 15:8 respectively.
- R10: A mode-reset access (code 7) turns persistent mode off and leaves the color and write-mask registers unchanged.
- R11: Idle, write and mode-reset cycles leave the color and write-mask registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasFall | input | 1 | Pulse: row strobe fell, cycleKind and dataIn valid |
| cycleKind | input | 3 | Cycle class from decoder (codes in R2) |
| casFall | input | 1 | Pulse: first column strobe fall, addr valid |
| casLowEn | input | 1 | Low-byte column strobe active at casFall |
| casHighEn | input | 1 | High-byte column strobe active at casFall |
| weFall | input | 1 | Pulse: write enable fell |
| addr | input | 9 | Column or block address |
| dataIn | input | 16 | Data pins |
| wrValid | output | 1 | Write request valid |
| colWe | output | 512 | Per-column write enables |
| bitEn | output | 16 | Per-I/O-bit write enables |
| wrData | output | 16 | Write data |

## Verification
The write request rises one clock after the edge that samples the later of weFall and the first casFall. The bench therefore checks that wrValid is low right after the earlier strobe. It checks the full request on the negative edge following the completing strobe, and confirms the request has dropped one cycle later. The rasFall data is checked only through the mask it produces. Register loads are only visible through later block writes and persistent-mode masked writes, so their effect is checked at the ports on the next access. Every sample is taken on the falling edge, halfway between the edges that drive and capture it.

// File: rtl/vwr_pkg.sv
package vwr_pkg;
  typedef enum logic [2:0] {
    CK_IDLE     = 3'd0,
    CK_WRITE    = 3'd1,
    CK_WRITE_M  = 3'd2,
    CK_BLOCK    = 3'd3,
    CK_BLOCK_M  = 3'd4,
    CK_LOAD_MSK = 3'd5,
    CK_LOAD_CLR = 3'd6,
    CK_MODE_RST = 3'd7
  } cycleKind_e;

  typedef struct packed {
    logic captureRowMask;
    logic captureCol;
    logic fire;
    logic clearPersist;
    logic isWrite;
    logic isBlock;
    logic isMasked;
    logic isLoadColor;
    logic isLoadMask;
  } vwrStrobe_t;
endpackage

// File: rtl/vwr_ctrl.sv
module vwr_ctrl
  import vwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasFall,
  input  logic [2:0] cycleKind,
  input  logic       casFall,
  input  logic       weFall,
  output vwrStrobe_t stb
);
  logic       active;
  logic       weSeen;
  logic       casSeen;
  cycleKind_e curKind;
  cycleKind_e newKind;
  logic       weNow;
  logic       casNow;
  logic       fireNow;

  assign newKind = cycleKind_e'(cycleKind);
  assign weNow   = weSeen | weFall;
  assign casNow  = casSeen | casFall;
  assign fireNow = active && !rasFall && weNow && casNow && (weFall || casFall);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      weSeen  <= 1'b0;
      casSeen <= 1'b0;
      curKind <= CK_IDLE;
    end else if (rasFall) begin
      active  <= (newKind != CK_IDLE) && (newKind != CK_MODE_RST);
      curKind <= newKind;
      weSeen  <= 1'b0;
      casSeen <= 1'b0;
    end else if (active) begin
      weSeen  <= weNow;
      casSeen <= casNow;
      if (fireNow) active <= 1'b0;
    end
  end

  always_comb begin
    stb = '0;
    stb.captureRowMask = rasFall && (newKind == CK_WRITE_M || newKind == CK_BLOCK_M);
    stb.clearPersist   = rasFall && (newKind == CK_MODE_RST);
    stb.captureCol     = active && !rasFall && casFall && !casSeen;
    stb.fire           = fireNow;
    stb.isWrite        = (curKind == CK_WRITE) || (curKind == CK_WRITE_M) ||
                         (curKind == CK_BLOCK) || (curKind == CK_BLOCK_M);
    stb.isBlock        = (curKind == CK_BLOCK) || (curKind == CK_BLOCK_M);
    stb.isMasked       = (curKind == CK_WRITE_M) || (curKind == CK_BLOCK_M);
    stb.isLoadColor    = (curKind == CK_LOAD_CLR);
    stb.isLoadMask     = (curKind == CK_LOAD_MSK);
  end
endmodule

// File: rtl/vwr_datapath.sv
module vwr_datapath
  import vwr_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  parameter int BLOCK  = 4,
  localparam int COLS    = 1 << ADDR_W,
  localparam int BLK_LOG = $clog2(BLOCK),
  localparam int HALF    = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  vwrStrobe_t        stb,
  input  logic              casLowEn,
  input  logic              casHighEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic              wrValid,
  output logic [COLS-1:0]   colWe,
  output logic [DATA_W-1:0] bitEn,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] colorReg,
  output logic              persist
);
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] rowMask;
  logic [ADDR_W-1:0] colAddr;
  logic              laneLo;
  logic              laneHi;

  logic [ADDR_W-1:0] colSel;
  logic              laneLoSel;
  logic              laneHiSel;
  logic [DATA_W-1:0] ioMask;
  logic [DATA_W-1:0] bitEnNext;
  logic [COLS-1:0]   colWeNext;

  assign colSel    = stb.captureCol ? addr      : colAddr;
  assign laneLoSel = stb.captureCol ? casLowEn  : laneLo;
  assign laneHiSel = stb.captureCol ? casHighEn : laneHi;

  always_comb begin
    if (!stb.isMasked)  ioMask = '1;
    else if (persist)   ioMask = maskReg;
    else                ioMask = rowMask;
    bitEnNext = ioMask & {{(DATA_W-HALF){laneHiSel}}, {HALF{laneLoSel}}};
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam logic [ADDR_W-1:0] CIDX = ADDR_W'(c);
    assign colWeNext[c] = stb.isBlock
      ? ((CIDX[ADDR_W-1:BLK_LOG] == colSel[ADDR_W-1:BLK_LOG]) && dataIn[c % BLOCK])
      : (CIDX == colSel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colorReg <= '0;
      maskReg  <= '0;
      persist  <= 1'b0;
      rowMask  <= '0;
      colAddr  <= '0;
      laneLo   <= 1'b0;
      laneHi   <= 1'b0;
      wrValid  <= 1'b0;
      colWe    <= '0;
      bitEn    <= '0;
      wrData   <= '0;
    end else begin
      wrValid <= 1'b0;
      colWe   <= '0;
      bitEn   <= '0;
      wrData  <= '0;
      if (stb.captureRowMask) rowMask <= dataIn;
      if (stb.clearPersist)   persist <= 1'b0;
      if (stb.captureCol) begin
        colAddr <= addr;
        laneLo  <= casLowEn;
        laneHi  <= casHighEn;
      end
      if (stb.fire) begin
        if (stb.isLoadColor) colorReg <= dataIn;
        if (stb.isLoadMask) begin
          maskReg <= dataIn;
          persist <= 1'b1;
        end
        if (stb.isWrite) begin
          wrValid <= 1'b1;
          colWe   <= colWeNext;
          bitEn   <= bitEnNext;
          wrData  <= stb.isBlock ? colorReg : dataIn;
        end
      end
    end
  end
endmodule

// File: rtl/vwr_mask_path.sv
module vwr_mask_path
  import vwr_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  parameter int BLOCK  = 4,
  localparam int COLS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasFall,
  input  logic [2:0]        cycleKind,
  input  logic              casFall,
  input  logic              casLowEn,
  input  logic              casHighEn,
  input  logic              weFall,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic              wrValid,
  output logic [COLS-1:0]   colWe,
  output logic [DATA_W-1:0] bitEn,
  output logic [DATA_W-1:0] wrData
);
  vwrStrobe_t        stb;
  logic [DATA_W-1:0] colorReg;
  logic              persist;

  vwr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rasFall(rasFall), .cycleKind(cycleKind),
    .casFall(casFall), .weFall(weFall), .stb(stb)
  );

  vwr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLOCK(BLOCK)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .casLowEn(casLowEn), .casHighEn(casHighEn),
    .addr(addr), .dataIn(dataIn), .wrValid(wrValid), .colWe(colWe),
    .bitEn(bitEn), .wrData(wrData), .colorReg(colorReg), .persist(persist)
  );
endmodule

// File: rtl/vwr_mask_path_chk.sv
module vwr_mask_path_chk
  import vwr_pkg::*;
#(
  parameter int COLS   = 512,
  parameter int DATA_W = 16,
  parameter int BLOCK  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              weFall,
  input logic              casFall,
  input logic              wrValid,
  input logic [COLS-1:0]   colWe,
  input logic [DATA_W-1:0] bitEn,
  input vwrStrobe_t        stb,
  input logic [DATA_W-1:0] colorReg,
  input logic              persist
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |-> (colWe == '0 && bitEn == '0));

  assert_latch_after_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> $past(weFall || casFall));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  assert_color_only_by_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(colorReg) |-> $past(stb.fire && stb.isLoadColor));

  assert_persist_set_by_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(persist) |-> $past(stb.fire && stb.isLoadMask));

  assert_block_width_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(colWe) <= BLOCK);
endmodule

bind vwr_mask_path vwr_mask_path_chk #(.COLS(COLS), .DATA_W(DATA_W), .BLOCK(BLOCK)) u_chk (
  .clk(clk), .rstN(rstN), .weFall(weFall), .casFall(casFall), .wrValid(wrValid),
  .colWe(colWe), .bitEn(bitEn), .stb(stb), .colorReg(colorReg), .persist(persist)
);

// File: tb/vwr_mask_path_bench.sv
`timescale 1ns/1ps
module vwr_mask_path_bench;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 16;
  localparam int BLOCK  = 4;
  localparam int COLS   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              rasFall, casFall, casLowEn, casHighEn, weFall;
  logic [2:0]        cycleKind;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dataIn;
  logic              wrValid;
  logic [COLS-1:0]   colWe;
  logic [DATA_W-1:0] bitEn, wrData;

  int checks = 0;
  int failures = 0;
  logic [DATA_W-1:0] mColor, mMask;
  logic              mPersist;

  always #2.5 clk = ~clk;

  vwr_mask_path u_vwr_mask_path (
    .clk(clk), .rstN(rstN), .rasFall(rasFall), .cycleKind(cycleKind),
    .casFall(casFall), .casLowEn(casLowEn), .casHighEn(casHighEn), .weFall(weFall),
    .addr(addr), .dataIn(dataIn), .wrValid(wrValid), .colWe(colWe),
    .bitEn(bitEn), .wrData(wrData)
  );

  task automatic check(input string req, input logic [COLS+DATA_W*2:0] act,
                       input logic [COLS+DATA_W*2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [COLS-1:0] expCols(input logic [2:0] kind,
      input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic [COLS-1:0] v = '0;
    if (kind == 3 || kind == 4) begin
      for (int k = 0; k < BLOCK; k++)
        if (d[k]) v[int'(a & ~ADDR_W'(BLOCK-1)) + k] = 1'b1;
    end else v[a] = 1'b1;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] expBits(input logic [2:0] kind,
      input logic [DATA_W-1:0] rowD, input logic lo, input logic hi);
    logic [DATA_W-1:0] m;
    if (kind == 2 || kind == 4) m = mPersist ? mMask : rowD;
    else m = '1;
    return m & {{8{hi}}, {8{lo}}};
  endfunction

  task automatic idleInputs();
    rasFall = 0; casFall = 0; weFall = 0; cycleKind = 0;
  endtask

  // order: 0 we first, 1 cas first, 2 same cycle
  task automatic access(input string req, input logic [2:0] kind, input logic [DATA_W-1:0] rowD,
      input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
      input logic lo, input logic hi, input int order);
    logic isWr;
    logic [COLS-1:0] eCols;
    logic [DATA_W-1:0] eBits, eData;
    isWr  = (kind >= 1 && kind <= 4);
    eCols = expCols(kind, a, d);
    eBits = expBits(kind, rowD, lo, hi);
    eData = (kind == 3 || kind == 4) ? mColor : d;
    @(negedge clk);
    rasFall = 1; cycleKind = kind; dataIn = rowD;
    @(negedge clk);
    idleInputs();
    if (kind == 7) mPersist = 0;
    if (kind == 0 || kind == 7) return;
    addr = a; casLowEn = lo; casHighEn = hi; dataIn = d;
    if (order == 2) begin
      casFall = 1; weFall = 1;
    end else begin
      if (order == 0) weFall = 1; else casFall = 1;
      @(negedge clk);
      idleInputs();
      check({req, " R2 early"}, {1'b0, wrValid}, '0);
      addr = ~a; casLowEn = ~lo; casHighEn = ~hi;
      if (order == 0) casFall = 1; else weFall = 1;
      if (order == 0) begin addr = a; casLowEn = lo; casHighEn = hi; end
    end
    @(negedge clk);
    idleInputs();
    if (isWr)
      check(req, {wrValid, colWe, bitEn, wrData}, {1'b1, eCols, eBits, eData});
    else
      check({req, " R3/R4 no write"}, {1'b0, wrValid}, '0);
    if (kind == 6) mColor = d;
    if (kind == 5) begin mMask = d; mPersist = 1; end
    @(negedge clk);
    check({req, " R2 pulse"}, {1'b0, wrValid}, '0);
  endtask

  initial begin
    #50000;
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; idleInputs(); casLowEn = 0; casHighEn = 0; addr = 0; dataIn = 0;
    mColor = 0; mMask = 0; mPersist = 0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {wrValid, colWe, bitEn, wrData}, '0);
    rstN = 1;
    // R1: color register zero after reset
    access("R1 color zero", 3, 16'h0, 9'd20, 16'h000F, 1, 1, 0);
    access("R5 plain write", 1, 16'h0, 9'd77, 16'hBEEF, 1, 1, 0);
    access("R6 masked rowmask", 2, 16'h0F0F, 9'd300, 16'h1234, 1, 1, 1);
    access("R9 low lane only", 1, 16'h0, 9'd5, 16'hAAAA, 1, 0, 2);
    access("R9 high lane only", 1, 16'h0, 9'd6, 16'h5555, 0, 1, 1);
    access("R3 load color", 6, 16'h0, 9'd0, 16'hC0DE, 1, 1, 0);
    access("R8 block write", 3, 16'h0, 9'd511, 16'hFFF5, 1, 1, 1);
    access("R4 load mask", 5, 16'h0, 9'd0, 16'h00F0, 1, 1, 2);
    access("R7 persistent masked", 4, 16'hFFFF, 9'd42, 16'h0006, 1, 1, 0);
    access("R11 idle", 0, 16'h1111, 9'd0, 16'h0, 1, 1, 0);
    access("R11 after plain write", 3, 16'h0, 9'd8, 16'h0009, 1, 1, 0);
    access("R10 mode reset", 7, 16'h0, 9'd0, 16'h0, 1, 1, 0);
    access("R10 rowmask again", 2, 16'h00FF, 9'd9, 16'h7777, 1, 1, 0);
    access("R11 mask kept after reset", 5, 16'h0, 9'd0, 16'hFF00, 1, 1, 0);
    access("R7 persist again", 2, 16'h000F, 9'd10, 16'h9999, 1, 1, 1);
    // R2: strobes with no open access are ignored
    @(negedge clk); weFall = 1; casFall = 1; addr = 9'd3;
    @(negedge clk); idleInputs();
    check("R2 stray strobes", {1'b0, wrValid}, '0);
    for (int i = 0; i < 300; i++) begin
      access("R5-R10 random", 3'($urandom_range(0, 7)), 16'($urandom),
             9'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
             int'($urandom_range(0, 2)));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule